// File: doc/BRIEF.md
# Parallel-Port Coprocessor Memory Loader

This block sits between a host's byte-wide parallel port and a coprocessor with its own 128 KB RAM. The host uses it to fill and inspect that RAM, to hold or release the coprocessor's reset, and to pick which 64 KB bank the coprocessor runs from. Two strobes drive it. An address strobe writes a small register set. A data strobe moves one byte between the host and the RAM. During data transfers a 7-bit byte index steps through one 128-byte sector. The sector lies inside a segment chosen by the last segment write.

A data strobe requests the coprocessor's bus. The byte moves only when the bus is granted or the coprocessor is held in reset. A strobe that arrives earlier waits inside the block until it can proceed. When the coprocessor makes an I/O access to the service port, the block raises a sticky service-request flag for the host. The host then reads the request block through the same data path.

All inputs are synchronous to `clk`. Each strobe acts once on its rising level, and the host drops it after `hst_done_o` pulses. The RAM is external, with a one-cycle synchronous read.

Top module: `pcl_top`

## Requirements
- R1: After synchronous reset: `cop_hold_o`=1, `cop_bank_o`=0, `hst_wait_o`=0, `hst_svc_o`=0, `hst_done_o`=0, `cop_busreq_o`=0. The segment, quarter and byte index are all 0.
- R2: An address-strobe write with `hst_reg_i` in 0..3 loads the quarter with `hst_reg_i[1:0]` and the segment with `hst_wdata_i`. Host RAM addresses are {quarter[1:0], segment[7:0], index[6:0]}, 17 bits, with the quarter in bits 16:15.
- R3: A data-strobe write (`hst_rnw_i`=0) stores `hst_wdata_i` at the current host address and then advances the index by one.
- R4: A data-strobe read (`hst_rnw_i`=1) returns the byte at the current host address on `hst_rdata_o` and then advances the index. When the transfer can proceed at once, `hst_done_o` pulses on the second clock edge after the edge that samples the strobe's rise.
- R5: The index wraps from 127 to 0 without changing the segment.
- R6: `hst_init_i` high at a clock edge returns the index to 0.
- R7: Address-strobe writes to registers 4..7 control the coprocessor. `hst_reg_i[1]` sets `cop_bank_o`, `hst_reg_i[0]`=0 holds reset and =1 releases it (4: hold, bank 0; 5: run, bank 0; 6: hold, bank 1; 7: run, bank 1).
- R8: `hst_wait_o` is high one cycle after a cycle in which `cop_busgnt_i` is low and the coprocessor is not held in reset, and low otherwise.
- R9: A data strobe that arrives while neither grant nor hold is present performs no RAM access and no `hst_done_o`. It completes once the grant arrives, and its byte is not lost.
- R10: `cop_busreq_o` follows `hst_dstb_i` one cycle later.
- R11: `cop_io_stb_i` with `cop_io_addr_i`=FFh sets `hst_svc_o`. Accesses to other ports leave it unchanged. It stays set until an address-strobe write or reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_dstb_i | input | 1 | Host data strobe, level |
| hst_astb_i | input | 1 | Host address strobe, level |
| hst_rnw_i | input | 1 | Data transfer direction, 1 = read |
| hst_init_i | input | 1 | Returns byte index to 0 |
| hst_reg_i | input | 3 | Register number for address-strobe writes |
| hst_wdata_i | input | 8 | Host write byte |
| hst_rdata_o | output | 8 | Host read byte |
| hst_done_o | output | 1 | One-cycle completion pulse |
| hst_wait_o | output | 1 | Transfers cannot proceed yet |
| hst_svc_o | output | 1 | Coprocessor service request |
| cop_busreq_o | output | 1 | Coprocessor bus request |
| cop_busgnt_i | input | 1 | Coprocessor bus granted |
| cop_hold_o | output | 1 | Coprocessor held in reset |
| cop_bank_o | output | 1 | Coprocessor 64 KB bank (RAM address bit 16) |
| cop_io_stb_i | input | 1 | Coprocessor I/O access strobe |
| cop_io_addr_i | input | 8 | Coprocessor I/O port number |
| ram_en_o | output | 1 | RAM access enable |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | 17 | RAM address |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data, one cycle after enable |

## Verification
The bench writes address-dependent bytes into all four quarters under a low, a middle and an all-ones segment. It then reads them back through the port. A mix-up of quarter, segment or index bits would put bytes at the wrong RAM locations, and the read-back shows it. A 130-byte burst followed by a read of a neighbouring segment's sentinel byte separates a correct 7-bit wrap from a carry into the segment. The remaining stimulus covers control writes, withheld grants and I/O accesses to service and non-service ports. These cases separate the reset and bank decode, the hold-off of a pending strobe and the stickiness of the service flag.

// File: rtl/pcl_pkg.sv
package pcl_pkg;
  // quarter select width: registers 0..3 pick one quarter of RAM
  localparam int QW   = 2;
  localparam int REGW = QW + 1;

  typedef struct packed {
    logic hold;
    logic bank;
  } cop_ctl_t;
endpackage

// File: rtl/pcl_edge.sv
module pcl_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] lvl_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) lvl_q[g] <= 1'b0;
      else     lvl_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~lvl_q[g];
  end
endmodule

// File: rtl/pcl_ctrl.sv
module pcl_ctrl
  import pcl_pkg::*;
#(
  parameter int          SEGW     = 8,
  parameter int          IOW      = 8,
  parameter logic [7:0]  SVC_PORT = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [REGW-1:0]   reg_i,
  input  logic [SEGW-1:0]   wdata_i,
  input  logic              io_stb_i,
  input  logic [IOW-1:0]    io_addr_i,
  output logic [SEGW-1:0]   seg_o,
  output logic [QW-1:0]     quarter_o,
  output cop_ctl_t          ctl_o,
  output logic              svc_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      seg_o     <= '0;
      quarter_o <= '0;
      ctl_o     <= '{hold: 1'b1, bank: 1'b0};
      svc_o     <= 1'b0;
    end else begin
      if (wr_i) begin
        if (!reg_i[REGW-1]) begin
          quarter_o <= reg_i[QW-1:0];
          seg_o     <= wdata_i;
        end else begin
          ctl_o.bank <= reg_i[1];
          ctl_o.hold <= ~reg_i[0];
        end
      end
      if (io_stb_i && io_addr_i == IOW'(SVC_PORT)) svc_o <= 1'b1;
      else if (wr_i)                               svc_o <= 1'b0;
    end
  end

  AST_SVC_STICKY: assert property (@(posedge clk) disable iff (rst)
    svc_o && !wr_i |=> svc_o);                                    // R11
  AST_HOLD_BY_CMD: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctl_o.hold) |-> $past(wr_i));                        // R7
  AST_SEG_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(seg_o));                                    // R2
endmodule

// File: rtl/pcl_xfer.sv
module pcl_xfer
  import pcl_pkg::*;
#(
  parameter int DW   = 8,
  parameter int IDXW = 7,
  parameter int SEGW = 8,
  localparam int AW  = QW + SEGW + IDXW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rise_i,
  input  logic            rnw_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            init_i,
  input  logic            rdy_i,
  input  logic [SEGW-1:0] seg_i,
  input  logic [QW-1:0]   quarter_i,
  output logic            ram_en_o,
  output logic            ram_we_o,
  output logic [AW-1:0]   ram_addr_o,
  output logic [DW-1:0]   ram_wdata_o,
  input  logic [DW-1:0]   ram_rdata_i,
  output logic [DW-1:0]   rd_data_o,
  output logic            done_o
);
  logic            pend_q, rnw_q;
  logic [DW-1:0]   wd_q;
  logic [IDXW-1:0] idx_q;
  logic            ph2_q, rdph_q;
  logic            pend, dir, fire;
  logic [DW-1:0]   wd;

  always_comb begin
    pend = pend_q | rise_i;
    dir  = rise_i ? rnw_i   : rnw_q;
    wd   = rise_i ? wdata_i : wd_q;
    fire = pend & rdy_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      rnw_q       <= 1'b0;
      wd_q        <= '0;
      idx_q       <= '0;
      ram_en_o    <= 1'b0;
      ram_we_o    <= 1'b0;
      ram_addr_o  <= '0;
      ram_wdata_o <= '0;
      ph2_q       <= 1'b0;
      rdph_q      <= 1'b0;
      done_o      <= 1'b0;
      rd_data_o   <= '0;
    end else begin
      pend_q <= pend & ~fire;
      if (rise_i) begin
        rnw_q <= rnw_i;
        wd_q  <= wdata_i;
      end
      ram_en_o    <= fire;
      ram_we_o    <= fire & ~dir;
      ram_addr_o  <= {quarter_i, seg_i, idx_q};
      ram_wdata_o <= wd;
      if (init_i)    idx_q <= '0;
      else if (fire) idx_q <= idx_q + 1'b1;
      ph2_q  <= ram_en_o;
      rdph_q <= ram_en_o & ~ram_we_o;
      done_o <= ph2_q;
      if (ph2_q && rdph_q) rd_data_o <= ram_rdata_i;
    end
  end

  AST_FIRE_READY: assert property (@(posedge clk) disable iff (rst)
    ram_en_o |-> $past(rdy_i));                                   // R9
  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (rst)
    fire && !init_i && (&idx_q) |=> idx_q == '0);                 // R5
  AST_INIT_ZERO: assert property (@(posedge clk) disable iff (rst)
    init_i |=> idx_q == '0);                                      // R6
  AST_DONE_AFTER_EN: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(ram_en_o, 2));                               // R4
endmodule

// File: rtl/pcl_top.sv
module pcl_top
  import pcl_pkg::*;
#(
  parameter int         DW       = 8,
  parameter int         IDXW     = 7,
  parameter int         SEGW     = 8,
  parameter int         IOW      = 8,
  parameter logic [7:0] SVC_PORT = 8'hFF,
  localparam int        AW       = QW + SEGW + IDXW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hst_dstb_i,
  input  logic            hst_astb_i,
  input  logic            hst_rnw_i,
  input  logic            hst_init_i,
  input  logic [REGW-1:0] hst_reg_i,
  input  logic [DW-1:0]   hst_wdata_i,
  output logic [DW-1:0]   hst_rdata_o,
  output logic            hst_done_o,
  output logic            hst_wait_o,
  output logic            hst_svc_o,
  output logic            cop_busreq_o,
  input  logic            cop_busgnt_i,
  output logic            cop_hold_o,
  output logic            cop_bank_o,
  input  logic            cop_io_stb_i,
  input  logic [IOW-1:0]  cop_io_addr_i,
  output logic            ram_en_o,
  output logic            ram_we_o,
  output logic [AW-1:0]   ram_addr_o,
  output logic [DW-1:0]   ram_wdata_o,
  input  logic [DW-1:0]   ram_rdata_i
);
  logic [1:0]      rise;
  logic [SEGW-1:0] seg;
  logic [QW-1:0]   quarter;
  cop_ctl_t        ctl;
  logic            x_done, a_done_q, wait_q, busreq_q;

  pcl_edge #(.N(2)) u_edge (
    .clk(clk), .rst(rst),
    .lvl_i({hst_astb_i, hst_dstb_i}),
    .rise_o(rise)
  );

  pcl_ctrl #(.SEGW(SEGW), .IOW(IOW), .SVC_PORT(SVC_PORT)) u_ctrl (
    .clk(clk), .rst(rst),
    .wr_i(rise[1]), .reg_i(hst_reg_i), .wdata_i(hst_wdata_i[SEGW-1:0]),
    .io_stb_i(cop_io_stb_i), .io_addr_i(cop_io_addr_i),
    .seg_o(seg), .quarter_o(quarter), .ctl_o(ctl), .svc_o(hst_svc_o)
  );

  pcl_xfer #(.DW(DW), .IDXW(IDXW), .SEGW(SEGW)) u_xfer (
    .clk(clk), .rst(rst),
    .rise_i(rise[0]), .rnw_i(hst_rnw_i), .wdata_i(hst_wdata_i),
    .init_i(hst_init_i), .rdy_i(cop_busgnt_i | ctl.hold),
    .seg_i(seg), .quarter_i(quarter),
    .ram_en_o(ram_en_o), .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o),
    .ram_wdata_o(ram_wdata_o), .ram_rdata_i(ram_rdata_i),
    .rd_data_o(hst_rdata_o), .done_o(x_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_done_q <= 1'b0;
      wait_q   <= 1'b0;
      busreq_q <= 1'b0;
    end else begin
      a_done_q <= rise[1];
      wait_q   <= ~(cop_busgnt_i | ctl.hold);
      busreq_q <= hst_dstb_i;
    end
  end

  assign hst_done_o   = x_done | a_done_q;
  assign hst_wait_o   = wait_q;
  assign cop_busreq_o = busreq_q;
  assign cop_hold_o   = ctl.hold;
  assign cop_bank_o   = ctl.bank;

  AST_WAIT_FLAG: assert property (@(posedge clk) disable iff (rst)
    hst_wait_o |-> $past(!cop_busgnt_i && !cop_hold_o));          // R8
  AST_BUSREQ_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    $rose(cop_busreq_o) |-> $past(hst_dstb_i));                   // R10
endmodule

// File: tb/sim_pcl_top.sv
module sim_pcl_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dstb = 0, astb = 0, rnw = 0, init = 0, gnt = 0, io_stb = 0;
  logic [2:0] regn = '0;
  logic [7:0] wd = '0, io_addr = '0;
  logic [7:0] rdata, ram_wdata, ram_rdata;
  logic       done, wt, svc, busreq, hold, bank, ram_en, ram_we;
  logic [16:0] ram_addr;
  logic [7:0] mem [0:131071];
  int         total = 0, bad = 0;
  bit         finished = 0;

  always #5 clk = ~clk;

  pcl_top u0 (
    .clk(clk), .rst(rst), .hst_dstb_i(dstb), .hst_astb_i(astb), .hst_rnw_i(rnw),
    .hst_init_i(init), .hst_reg_i(regn), .hst_wdata_i(wd), .hst_rdata_o(rdata),
    .hst_done_o(done), .hst_wait_o(wt), .hst_svc_o(svc), .cop_busreq_o(busreq),
    .cop_busgnt_i(gnt), .cop_hold_o(hold), .cop_bank_o(bank),
    .cop_io_stb_i(io_stb), .cop_io_addr_i(io_addr), .ram_en_o(ram_en),
    .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata),
    .ram_rdata_i(ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      ram_rdata <= mem[ram_addr];
    end
  end

  function automatic logic [7:0] pat(input logic [16:0] a);
    return 8'((a * 37) + (a >> 8) + 8'h5B);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_done(input string req);
    bit seen = 0;
    for (int k = 0; k < 40 && !seen; k++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    if (!seen) chk(0, req, 0, 1);
  endtask

  task automatic areg(input logic [2:0] r, input logic [7:0] v);
    @(negedge clk); regn = r; wd = v; astb = 1;
    wait_done("R2");
    astb = 0;
    @(negedge clk);
  endtask

  task automatic dwrite(input logic [7:0] v);
    @(negedge clk); rnw = 0; wd = v; dstb = 1;
    wait_done("R3");
    dstb = 0;
    @(negedge clk);
  endtask

  task automatic dread(output logic [7:0] v);
    @(negedge clk); rnw = 1; dstb = 1;
    wait_done("R4");
    v = rdata;
    dstb = 0;
    @(negedge clk);
  endtask

  task automatic pulse_init();
    @(negedge clk); init = 1;
    @(negedge clk); init = 0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] segs [3];
    logic [16:0] a;
    segs[0] = 8'h00; segs[1] = 8'h5A; segs[2] = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(hold == 1 && bank == 0, "R1 hold/bank", {hold, bank}, 2'b10);
    chk(wt == 0 && svc == 0 && done == 0 && busreq == 0, "R1 flags",
        {wt, svc, done, busreq}, 0);

    // R2 R3 sweep: quarters x segments, 4 bytes each
    for (int q = 0; q < 4; q++) begin
      for (int s = 0; s < 3; s++) begin
        areg(3'(q), segs[s]);
        pulse_init();
        for (int i = 0; i < 4; i++) begin
          a = {2'(q), segs[s], 7'(i)};
          dwrite(pat(a));
        end
        for (int i = 0; i < 4; i++) begin
          a = {2'(q), segs[s], 7'(i)};
          chk(mem[a] === pat(a), "R2 R3 stored byte", mem[a], pat(a));
        end
      end
    end
    // R4 read back sweep
    for (int q = 0; q < 4; q++) begin
      for (int s = 0; s < 3; s++) begin
        areg(3'(q), segs[s]);
        pulse_init();
        for (int i = 0; i < 4; i++) begin
          a = {2'(q), segs[s], 7'(i)};
          dread(v);
          chk(v === pat(a), "R4 read byte", v, pat(a));
        end
      end
    end

    // R4 latency: done on third negedge after strobe raised
    areg(3'd2, 8'h5A); pulse_init();
    @(negedge clk); rnw = 1; dstb = 1;
    @(negedge clk); chk(done == 0, "R4 early done", done, 0);
    @(negedge clk); chk(done == 0, "R4 early done", done, 0);
    @(negedge clk); chk(done == 1, "R4 done timing", done, 1);
    chk(rdata === pat({2'd2, 8'h5A, 7'd0}), "R4 timed data", rdata,
        pat({2'd2, 8'h5A, 7'd0}));
    dstb = 0; @(negedge clk);

    // R5 wrap: sentinel in segment 4, 130 bytes into segment 3
    areg(3'd1, 8'h04); pulse_init(); dwrite(8'hC3);
    areg(3'd1, 8'h03); pulse_init();
    for (int i = 0; i < 130; i++) dwrite(8'(i + 8'h40));
    pulse_init();
    dread(v); chk(v === 8'(128 + 8'h40), "R5 wrap idx0", v, 8'(128 + 8'h40));
    dread(v); chk(v === 8'(129 + 8'h40), "R5 wrap idx1", v, 8'(129 + 8'h40));
    dread(v); chk(v === 8'(2 + 8'h40), "R5 idx2", v, 8'(2 + 8'h40));
    chk(mem[{2'd1, 8'h03, 7'd127}] === 8'(127 + 8'h40), "R5 idx127",
        mem[{2'd1, 8'h03, 7'd127}], 8'(127 + 8'h40));
    areg(3'd1, 8'h04); pulse_init();
    dread(v); chk(v === 8'hC3, "R5 no carry into segment", v, 8'hC3);

    // R6 init mid-sector
    areg(3'd0, 8'h10); pulse_init();
    for (int i = 0; i < 5; i++) dwrite(8'(8'hA0 + i));
    pulse_init();
    dread(v); chk(v === 8'hA0, "R6 index reset", v, 8'hA0);

    // R7 control registers
    areg(3'd5, 8'h00); chk(hold == 0 && bank == 0, "R7 reg5", {hold, bank}, 2'b00);
    areg(3'd7, 8'h00); chk(hold == 0 && bank == 1, "R7 reg7", {hold, bank}, 2'b01);
    areg(3'd6, 8'h00); chk(hold == 1 && bank == 1, "R7 reg6", {hold, bank}, 2'b11);
    areg(3'd4, 8'h00); chk(hold == 1 && bank == 0, "R7 reg4", {hold, bank}, 2'b10);

    // R8 wait flag
    gnt = 0;
    areg(3'd5, 8'h00);
    @(negedge clk); chk(wt == 1, "R8 wait when running ungranted", wt, 1);
    gnt = 1;
    @(negedge clk); chk(wt == 0, "R8 wait cleared by grant", wt, 0);
    gnt = 0;
    @(negedge clk); chk(wt == 1, "R8 wait again", wt, 1);

    // R9 R10 hold-off with no grant
    areg(3'd3, 8'h21); pulse_init();
    @(negedge clk); rnw = 0; wd = 8'h9E; dstb = 1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (done) chk(0, "R9 done without grant", 1, 0);
    end
    chk(busreq == 1, "R10 busreq high", busreq, 1);
    chk(mem[{2'd3, 8'h21, 7'd0}] !== 8'h9E, "R9 no early write",
        mem[{2'd3, 8'h21, 7'd0}], 0);
    dstb = 0;
    @(negedge clk); chk(busreq == 0, "R10 busreq low", busreq, 0);
    gnt = 1;
    wait_done("R9");
    chk(mem[{2'd3, 8'h21, 7'd0}] === 8'h9E, "R9 byte kept",
        mem[{2'd3, 8'h21, 7'd0}], 8'h9E);
    gnt = 0;
    areg(3'd4, 8'h00);

    // R11 service request
    @(negedge clk); io_addr = 8'h12; io_stb = 1;
    @(negedge clk); io_stb = 0;
    @(negedge clk); chk(svc == 0, "R11 other port ignored", svc, 0);
    io_addr = 8'hFF; io_stb = 1;
    @(negedge clk); io_stb = 0;
    chk(svc == 1, "R11 set", svc, 1);
    repeat (5) @(negedge clk);
    chk(svc == 1, "R11 sticky", svc, 1);
    areg(3'd0, 8'h00);
    chk(svc == 0, "R11 cleared by address write", svc, 0);
    io_stb = 1;
    @(negedge clk); io_stb = 0; rst = 1;
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk(svc == 0 && hold == 1, "R11 R1 cleared by reset", {svc, hold}, 2'b01);

    finished = 1;
    finish_run();
  end
endmodule